// File: doc/BRIEF.md
# Buck Switch Sequencing Controller

This block is the digital sequencing core of a synchronous step-down converter. It drives two gate-enable outputs, one for the high-side switch and one for the low-side synchronous rectifier. Its inputs are comparator decisions, already reduced to digital levels: output below the regulation window, PWM comparator trip, current limit, inductor zero crossing and output overvoltage. A cycle-clock input and a mode bit complete the set. All time intervals are counted in system-clock cycles.

The mode bit selects one of two regulation schemes. In fixed-frequency PWM mode, each rising edge of the cycle clock starts a peak-current cycle. In pulsed mode, the low-output comparator starts a fixed-peak burst that the current limit ends. Both schemes share a single state machine. That machine inserts a dead interval on every gate handover, holds the high-side switch for a minimum on-time, and hands the rectifier off either at the next cycle edge (continuous conduction) or on zero crossing (discontinuous conduction). A threshold-select output tells the analog current-limit comparator which peak level applies.

Top module: `buck_seq_ctrl`

## Requirements
- R1: In PWM mode (mode bit 1), a rising edge of the cycle clock seen while idle turns the high-side gate on at the next clock. Once the minimum on-time has elapsed, an asserted PWM trip turns it off.
- R2: The two gates are never on together. Between the high-side gate turning off and the low-side gate turning on, both stay off for exactly DEAD_CYC cycles.
- R3: In PWM mode, a cycle-clock rising edge while the low-side gate is on turns the low-side gate off at the next clock. The high-side gate then turns on after DEAD_CYC cycles with both gates off.
- R4: An asserted zero-crossing input turns the low-side gate off at the next clock. In PWM mode the block then waits for a new cycle-clock edge before the high-side gate turns on again.
- R5: In pulsed mode (mode bit 0), an asserted low-output input starts a cycle while idle. Only the current limit ends the high-side on-time; the PWM trip input has no effect. The low-side gate then stays on until zero crossing.
- R6: In pulsed mode, if the low-output input is asserted when the dead interval after the low-side gate ends, the high-side gate turns on immediately, with no idle cycle.
- R7: The current-limit input ends the high-side on-time in both modes. The threshold-select output is 1 (high peak limit) in PWM mode and 0 (low peak limit) in pulsed mode.
- R8: In PWM mode, asserted overvoltage ends the high-side on-time once the minimum on-time has passed, and no new cycle starts while it is asserted. Cycles resume on the first cycle-clock edge after it deasserts.
- R9: Every high-side pulse lasts at least MIN_ON_CYC cycles, whatever termination input arrives early. Only disable and reset can cut a pulse short.
- R10: Cycle-clock edges that arrive while the high-side gate is on are ignored. The gate can therefore stay on across any number of cycle periods (100 % duty).
- R11: Asynchronous reset, or a low enable sampled at a clock edge, turns both gates off at that edge and returns the block to idle. After reset the threshold-select output is 0.
- R12: The mode bit is captured only while both gates are off and the block is idle. The captured value, shown on the threshold-select output one cycle later, holds for the rest of the switching cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces both gates off |
| mode_pwm | input | 1 | 1 = fixed-frequency PWM, 0 = pulsed mode |
| cyc_clk | input | 1 | Cycle clock; rising edge starts a PWM cycle |
| fb_low | input | 1 | Output below regulation window |
| pwm_trip | input | 1 | PWM comparator: sensed current plus ramp above error level |
| ilim | input | 1 | Peak current limit reached |
| zcross | input | 1 | Inductor current reached zero |
| ovp | input | 1 | Output above overvoltage threshold |
| hs_on | output | 1 | High-side switch gate enable |
| ls_on | output | 1 | Low-side rectifier gate enable |
| ilim_sel | output | 1 | Peak-limit select: 1 high (PWM), 0 low (pulsed) |

## Verification
A start condition seen while idle (a cycle-clock rise or a low-output input) shows up on the high-side gate one clock later. The same one-clock delay applies to an early trip: it takes effect one clock after the MIN_ON_CYC-th cycle of the pulse. After that, the low-side gate rises after exactly DEAD_CYC further cycles. Zero crossing, a CCM cycle edge and disable each remove the active gate one clock after they are sampled. Mode capture reaches the threshold-select output one clock after an idle cycle. The bench drives inputs just after a falling edge and samples outputs at the next falling edge, so every expected value is placed at a falling-edge index counted from these latencies.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HIGH   = 3'd1,
        ST_GAP_HL = 3'd2,
        ST_LOW    = 3'd3,
        ST_GAP_LH = 3'd4
    } seq_state_t;

    typedef struct packed {
        seq_state_t state;
        logic       mode;   // captured mode: 1 PWM, 0 pulsed
        logic       pend;   // PWM cycle edge waiting for the dead gap to end
    } seq_regs_t;

endpackage

// File: rtl/buck_seq_timer.sv
module buck_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/buck_seq_edge.sv
module buck_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_d, lvl_q;

    always_comb lvl_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
    import buck_seq_pkg::*;
#(
    parameter int DEAD_CYC   = 4,
    parameter int MIN_ON_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode_pwm,
    input  logic cyc_clk,
    input  logic fb_low,
    input  logic pwm_trip,
    input  logic ilim,
    input  logic zcross,
    input  logic ovp,
    output logic hs_on,
    output logic ls_on,
    output logic ilim_sel
);
    localparam int DEAD_W = $clog2(DEAD_CYC + 1);
    localparam int MIN_W  = $clog2(MIN_ON_CYC + 1);
    localparam logic [DEAD_W-1:0] DEAD_LOAD = DEAD_W'(DEAD_CYC - 1);
    localparam logic [MIN_W-1:0]  MIN_LOAD  = MIN_W'(MIN_ON_CYC - 1);

    seq_regs_t d, q;
    logic      rise, min_done, dead_done, min_load, dead_load, end_req, tail_go;

    buck_seq_edge u_edge (
        .clk (clk), .rst_n (rst_n), .lvl (cyc_clk), .rise (rise)
    );

    buck_seq_timer #(.W(MIN_W)) u_min_on (
        .clk (clk), .rst_n (rst_n), .load (min_load),
        .load_val (MIN_LOAD), .done (min_done)
    );

    buck_seq_timer #(.W(DEAD_W)) u_dead (
        .clk (clk), .rst_n (rst_n), .load (dead_load),
        .load_val (DEAD_LOAD), .done (dead_done)
    );

    always_comb begin
        d         = q;
        min_load  = 1'b0;
        dead_load = 1'b0;
        end_req   = ilim || (q.mode && (pwm_trip || ovp));
        tail_go   = q.mode ? ((q.pend || rise) && !ovp) : fb_low;
        case (q.state)
            ST_IDLE: begin
                d.mode = mode_pwm;
                d.pend = 1'b0;
                if (mode_pwm ? (rise && !ovp) : fb_low) begin
                    d.state  = ST_HIGH;
                    min_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (min_done && end_req) begin
                    d.state   = ST_GAP_HL;
                    dead_load = 1'b1;
                end
            end
            ST_GAP_HL: begin
                if (dead_done) d.state = ST_LOW;
            end
            ST_LOW: begin
                if (q.mode && rise) begin
                    d.state   = ST_GAP_LH;
                    d.pend    = 1'b1;
                    dead_load = 1'b1;
                end else if (zcross) begin
                    d.state   = ST_GAP_LH;
                    dead_load = 1'b1;
                end
            end
            ST_GAP_LH: begin
                if (q.mode && rise) d.pend = 1'b1;
                if (dead_done) begin
                    d.pend = 1'b0;
                    if (tail_go) begin
                        d.state  = ST_HIGH;
                        min_load = 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (!en) begin
            d.state = ST_IDLE;
            d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, mode: 1'b0, pend: 1'b0};
        else        q <= d;
    end

    assign hs_on    = (q.state == ST_HIGH);
    assign ls_on    = (q.state == ST_LOW);
    assign ilim_sel = q.mode;

    // Observation counters for the timing properties below.
    logic [MIN_W-1:0]  on_cnt_q;
    logic [DEAD_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_cnt_q <= '0;
            gap_q    <= '0;
        end else begin
            if (!hs_on)                             on_cnt_q <= '0;
            else if (on_cnt_q != MIN_W'(MIN_ON_CYC)) on_cnt_q <= on_cnt_q + 1'b1;
            if (hs_on || ls_on)                     gap_q <= '0;
            else if (gap_q != DEAD_W'(DEAD_CYC))    gap_q <= gap_q + 1'b1;
        end
    end

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    p_dead_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> gap_q >= DEAD_W'(DEAD_CYC));

    p_min_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_on) && $past(en) |-> on_cnt_q >= MIN_W'(MIN_ON_CYC));

    p_disable_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hs_on && !ls_on);

    p_ovp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_on && ovp && ilim_sel && mode_pwm |=> !hs_on);

    p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hs_on || ls_on) && (hs_on || ls_on) |-> $stable(ilim_sel));
endmodule

// File: tb/tb_buck_seq_ctrl.sv
module tb_buck_seq_ctrl;
    logic clk = 1'b0;
    logic rst_n, en, mode_pwm, cyc_clk, fb_low, pwm_trip, ilim, zcross, ovp;
    logic hs_on, ls_on, ilim_sel;
    int   errors = 0;
    int   checks = 0;
    bit   done_flag = 1'b0;

    always #10 clk = ~clk;

    buck_seq_ctrl #(.DEAD_CYC(4), .MIN_ON_CYC(8)) dut (
        .clk (clk), .rst_n (rst_n), .en (en), .mode_pwm (mode_pwm),
        .cyc_clk (cyc_clk), .fb_low (fb_low), .pwm_trip (pwm_trip),
        .ilim (ilim), .zcross (zcross), .ovp (ovp),
        .hs_on (hs_on), .ls_on (ls_on), .ilim_sel (ilim_sel)
    );

    // {en, mode, cyc, fb, trip, ilim, zc, ovp, exp_hs, exp_ls}
    // expected bits are checked before the row's inputs are applied
    localparam int NV = 23;
    localparam logic [9:0] VEC [NV] = '{
        10'b1100000000, 10'b1110000000, 10'b1110100010, 10'b1110100010,
        10'b1110100010, 10'b1100100010, 10'b1100100010, 10'b1100100010,
        10'b1100100010, 10'b1100100010, 10'b1100000000, 10'b1100000000,
        10'b1100000000, 10'b1100000000, 10'b1100000001, 10'b1100000001,
        10'b1110000001, 10'b1110000000, 10'b1110000000, 10'b1110000000,
        10'b1110000000, 10'b1110000010, 10'b1110000010
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        en = 0; mode_pwm = 0; cyc_clk = 0; fb_low = 0;
        pwm_trip = 0; ilim = 0; zcross = 0; ovp = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic edge_cyc();
        cyc_clk = 1'b0; tick(1);
        cyc_clk = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 reset hs", hs_on, 1'b0);
        chk("R11 reset ls", ls_on, 1'b0);
        chk("R11 reset ilim_sel", ilim_sel, 1'b0);

        // Table: PWM start (R1), min on-time (R9), dead gap (R2), CCM edge (R3)
        for (int i = 0; i < NV; i++) begin
            chk($sformatf("R1/R2/R3/R9 vec%0d hs", i), hs_on, VEC[i][1]);
            chk($sformatf("R1/R2/R3/R9 vec%0d ls", i), ls_on, VEC[i][0]);
            {en, mode_pwm, cyc_clk, fb_low, pwm_trip, ilim, zcross, ovp} = VEC[i][9:2];
            tick(1);
        end

        // PWM: current limit ends pulse (R7), zero crossing (R4)
        do_reset();
        en = 1; mode_pwm = 1; tick(1);
        chk("R7 ilim_sel pwm", ilim_sel, 1'b1);
        cyc_clk = 1; tick(1);
        chk("R1 hs on after edge", hs_on, 1'b1);
        ilim = 1; tick(7);
        chk("R9 hs held to min", hs_on, 1'b1);
        tick(1);
        chk("R7 ilim ends hs", hs_on, 1'b0);
        ilim = 0; tick(4);
        chk("R2 ls after dead", ls_on, 1'b1);
        zcross = 1; tick(1);
        chk("R4 zc ends ls", ls_on, 1'b0);
        zcross = 0; tick(10);
        chk("R4 waits for edge", hs_on, 1'b0);
        edge_cyc(); tick(1);
        chk("R1 restart on edge", hs_on, 1'b1);

        // R10: edges during on-time ignored
        for (int k = 0; k < 8; k++) begin
            cyc_clk = 0; tick(2);
            cyc_clk = 1; tick(3);
        end
        chk("R10 hs stays on", hs_on, 1'b1);
        chk("R10 ls stays off", ls_on, 1'b0);

        // R8: overvoltage ends pulse and blocks restarts
        ovp = 1; tick(1);
        chk("R8 ovp ends hs", hs_on, 1'b0);
        tick(4);
        chk("R8 ls after dead", ls_on, 1'b1);
        edge_cyc(); tick(1);
        chk("R3 edge ends ls", ls_on, 1'b0);
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 24; k++) begin
                cyc_clk = (k % 6) < 3;
                tick(1);
                if (hs_on) seen = 1'b1;
            end
            chk("R8 no start under ovp", seen, 1'b0);
        end
        ovp = 0;
        edge_cyc(); tick(1);
        chk("R8 resume after ovp", hs_on, 1'b1);

        // R11: disable
        en = 0; tick(1);
        chk("R11 disable hs", hs_on, 1'b0);
        chk("R11 disable ls", ls_on, 1'b0);
        edge_cyc(); tick(2);
        chk("R11 disabled stays off", hs_on, 1'b0);

        // Pulsed mode: R5, R6, R7, R12
        do_reset();
        en = 1; mode_pwm = 0; fb_low = 1; tick(1);
        chk("R5 fb starts hs", hs_on, 1'b1);
        chk("R7 ilim_sel pulsed", ilim_sel, 1'b0);
        fb_low = 0; pwm_trip = 1; tick(15);
        chk("R5 trip ignored pulsed", hs_on, 1'b1);
        pwm_trip = 0; ilim = 1; tick(1);
        chk("R5 ilim ends hs", hs_on, 1'b0);
        ilim = 0; tick(4);
        chk("R2 pulsed ls after dead", ls_on, 1'b1);
        mode_pwm = 1; tick(10);
        chk("R5 ls held until zc", ls_on, 1'b1);
        chk("R12 mode held in cycle", ilim_sel, 1'b0);
        mode_pwm = 0; zcross = 1; tick(1);
        chk("R5 zc ends ls", ls_on, 1'b0);
        zcross = 0; fb_low = 1; tick(3);
        chk("R6 gap before restart", hs_on, 1'b0);
        tick(1);
        chk("R6 immediate restart", hs_on, 1'b1);
        fb_low = 0; ilim = 1; tick(8);
        chk("R9 pulsed min on", hs_on, 1'b0);
        ilim = 0; tick(4);
        chk("R5 ls second burst", ls_on, 1'b1);
        zcross = 1; tick(1);
        zcross = 0; tick(4);
        chk("R5 idle after burst", hs_on, 1'b0);
        mode_pwm = 1; tick(1);
        chk("R12 mode captured idle", ilim_sel, 1'b1);

        done_flag = 1'b1;
        finish_run();
    end
endmodule